// File: doc/BRIEF.md
# Configuration Space Access Requester

This block turns single commands from user logic into requests on a PCI Express configuration management port. Each command carries a byte address, a function number, a read/write flag and, for writes, 32-bit data, a 4-bit byte-enable mask and a debug flag. The block latches the command. It divides the byte address by four to form the 10-bit dword address the port expects. It raises either the read or the write strobe and holds every request signal unchanged until the port reports completion with its done strobe. The port may take any number of cycles to do this.

When done arrives, the block drops its strobe on the next clock edge. It captures the read data that is valid only in the done cycle. It then returns a one-cycle response pulse to the user. Only one transaction is in flight at a time, and the command port stays not-ready until the current transaction completes. The debug flag lets a write reach certain read-only fields of a root port's configuration header. The block forwards this flag only with writes.

Top module: `cfg_access_req`

## Requirements
- R1: After reset, cmd_ready_o is 1 and mgmt_rd_o, mgmt_wr_o, mgmt_dbg_o and rsp_valid_o are 0.
- R2: mgmt_addr_o equals cmd_byte_addr_i[11:2] of the accepted command, so bits [1:0] are ignored (byte 0x04 gives dword 0x01, byte 0x10 gives 0x04). mgmt_func_o equals the accepted function number.
- R3: From the cycle after acceptance until done is seen, the active strobe stays 1. mgmt_addr_o, mgmt_func_o, mgmt_wdata_o and mgmt_be_o stay unchanged during this time.
- R4: In the cycle after a cycle where mgmt_done_i is 1 with a strobe active, mgmt_rd_o and mgmt_wr_o are both 0.
- R5: A read command (cmd_write_i=0) raises only mgmt_rd_o. A write command raises only mgmt_wr_o and carries its data and byte-enable mask unchanged. A write with mask 4'b0000 is still issued and completes.
- R6: cmd_ready_o is 0 from the cycle after acceptance until the done cycle. It returns to 1 in the cycle after done.
- R7: rsp_valid_o is a one-cycle pulse in the cycle after each done. rsp_write_o gives the kind of the finished command (1 = write). For reads, rsp_rdata_o holds mgmt_rdata_i as sampled in the done cycle.
- R8: mgmt_dbg_o equals cmd_dbg_i of an accepted write for the duration of that write. It is 0 for reads and whenever no write is active.
- R9: mgmt_done_i while no transaction is active is ignored: it produces no response pulse and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block can accept a command |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_byte_addr_i | input | 12 | Configuration byte address |
| cmd_func_i | input | 8 | Function number |
| cmd_wdata_i | input | 32 | Write data |
| cmd_be_i | input | 4 | Write byte-enable mask |
| cmd_dbg_i | input | 1 | Debug access for writes to read-only fields |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_write_o | output | 1 | Completed command was a write |
| rsp_rdata_o | output | 32 | Captured read data |
| mgmt_addr_o | output | 10 | Dword address to management port |
| mgmt_func_o | output | 8 | Function number to management port |
| mgmt_wdata_o | output | 32 | Write data to management port |
| mgmt_be_o | output | 4 | Byte enables to management port |
| mgmt_wr_o | output | 1 | Write strobe |
| mgmt_rd_o | output | 1 | Read strobe |
| mgmt_dbg_o | output | 1 | Debug access qualifier |
| mgmt_rdata_i | input | 32 | Read data, valid in the done cycle |
| mgmt_done_i | input | 1 | Read/write completion strobe |

## Verification
The hardest case is done arriving in the very first strobe cycle while the user already holds the next command. Here the strobe must fall and ready must rise in the same cycle, and the next request must follow immediately. The bench's port responder has a programmable latency, including zero. The driver queues commands back to back, so zero-latency completions meet a waiting command. A done pulse injected while the block is idle covers the ignored-strobe case.

// File: rtl/cfgreq_pkg.sv
package cfgreq_pkg;
  parameter int unsigned DW_ADDR_W = 10;
  parameter int unsigned FUNC_W    = 8;
  parameter int unsigned DATA_W    = 32;
  localparam int unsigned BE_W     = DATA_W / 8;
  localparam int unsigned BYTE_SH  = $clog2(BE_W);
  localparam int unsigned BADDR_W  = DW_ADDR_W + BYTE_SH;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} req_state_e;

  typedef struct packed {
    logic                 dbg;
    logic [DW_ADDR_W-1:0] addr;
    logic [FUNC_W-1:0]    func;
    logic [DATA_W-1:0]    wdata;
    logic [BE_W-1:0]      be;
  } mgmt_req_t;
endpackage

// File: rtl/cfgreq_fsm.sv
module cfgreq_fsm
  import cfgreq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic cmd_write_i,
  input  logic mgmt_done_i,
  output logic cmd_ready_o,
  output logic load_o,
  output logic finish_o,
  output logic mgmt_wr_o,
  output logic mgmt_rd_o
);
  req_state_e st_q;

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign load_o      = cmd_valid_i && cmd_ready_o;
  assign finish_o    = !cmd_ready_o && mgmt_done_i;
  assign mgmt_wr_o   = (st_q == ST_WRITE);
  assign mgmt_rd_o   = (st_q == ST_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       st_q <= ST_IDLE;
    else if (load_o)   st_q <= cmd_write_i ? ST_WRITE : ST_READ;
    else if (finish_o) st_q <= ST_IDLE;  // strobe falls the cycle after done
  end
endmodule

// File: rtl/cfgreq_hold.sv
module cfgreq_hold
  import cfgreq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               cmd_write_i,
  input  logic [BADDR_W-1:0] cmd_byte_addr_i,
  input  logic [FUNC_W-1:0]  cmd_func_i,
  input  logic [DATA_W-1:0]  cmd_wdata_i,
  input  logic [BE_W-1:0]    cmd_be_i,
  input  logic               cmd_dbg_i,
  output mgmt_req_t          req_o
);
  mgmt_req_t req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
    end else if (load_i) begin
      req_q.addr  <= cmd_byte_addr_i[BADDR_W-1:BYTE_SH];
      req_q.func  <= cmd_func_i;
      req_q.wdata <= cmd_wdata_i;
      req_q.be    <= cmd_be_i;
      req_q.dbg   <= cmd_dbg_i && cmd_write_i;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/cfgreq_rsp.sv
module cfgreq_rsp
  import cfgreq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              finish_i,
  input  logic              was_write_i,
  input  logic [DATA_W-1:0] mgmt_rdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_write_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_write_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= finish_i;
      if (finish_i) begin
        rsp_write_o <= was_write_i;
        // read data is only valid in the done cycle
        if (!was_write_i) rsp_rdata_o <= mgmt_rdata_i;
      end
    end
  end
endmodule

// File: rtl/cfg_access_req.sv
module cfg_access_req
  import cfgreq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic               cmd_write_i,
  input  logic [BADDR_W-1:0] cmd_byte_addr_i,
  input  logic [FUNC_W-1:0]  cmd_func_i,
  input  logic [DATA_W-1:0]  cmd_wdata_i,
  input  logic [BE_W-1:0]    cmd_be_i,
  input  logic               cmd_dbg_i,
  output logic               rsp_valid_o,
  output logic               rsp_write_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic [DW_ADDR_W-1:0] mgmt_addr_o,
  output logic [FUNC_W-1:0]  mgmt_func_o,
  output logic [DATA_W-1:0]  mgmt_wdata_o,
  output logic [BE_W-1:0]    mgmt_be_o,
  output logic               mgmt_wr_o,
  output logic               mgmt_rd_o,
  output logic               mgmt_dbg_o,
  input  logic [DATA_W-1:0]  mgmt_rdata_i,
  input  logic               mgmt_done_i
);
  logic      load, finish;
  mgmt_req_t req;

  cfgreq_fsm u_fsm (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_write_i, .mgmt_done_i,
    .cmd_ready_o, .load_o(load), .finish_o(finish), .mgmt_wr_o, .mgmt_rd_o
  );

  cfgreq_hold u_hold (
    .clk_i, .rst_ni, .load_i(load), .cmd_write_i, .cmd_byte_addr_i,
    .cmd_func_i, .cmd_wdata_i, .cmd_be_i, .cmd_dbg_i, .req_o(req)
  );

  cfgreq_rsp u_rsp (
    .clk_i, .rst_ni, .finish_i(finish), .was_write_i(mgmt_wr_o), .mgmt_rdata_i,
    .rsp_valid_o, .rsp_write_o, .rsp_rdata_o
  );

  assign mgmt_addr_o  = req.addr;
  assign mgmt_func_o  = req.func;
  assign mgmt_wdata_o = req.wdata;
  assign mgmt_be_o    = req.be;
  assign mgmt_dbg_o   = req.dbg && mgmt_wr_o;
endmodule

// File: rtl/cfgreq_chk.sv
module cfgreq_chk
  import cfgreq_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_valid_i,
  input logic                 cmd_ready_o,
  input logic [BADDR_W-1:0]   cmd_byte_addr_i,
  input logic                 rsp_valid_o,
  input logic [DW_ADDR_W-1:0] mgmt_addr_o,
  input logic [FUNC_W-1:0]    mgmt_func_o,
  input logic [DATA_W-1:0]    mgmt_wdata_o,
  input logic [BE_W-1:0]      mgmt_be_o,
  input logic                 mgmt_wr_o,
  input logic                 mgmt_rd_o,
  input logic                 mgmt_dbg_o,
  input logic                 mgmt_done_i
);
  logic active;
  assign active = mgmt_wr_o || mgmt_rd_o;

  a_r2_dword_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> (mgmt_addr_o == $past(cmd_byte_addr_i[BADDR_W-1:BYTE_SH])));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !mgmt_done_i) |=> ($stable(mgmt_wr_o) && $stable(mgmt_rd_o) && $stable(mgmt_addr_o)
      && $stable(mgmt_func_o) && $stable(mgmt_wdata_o) && $stable(mgmt_be_o)));

  a_r4_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && mgmt_done_i) |=> !active);

  a_r5_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mgmt_wr_o, mgmt_rd_o}));

  a_r6_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> !cmd_ready_o);

  a_r7_rsp_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && mgmt_done_i) |=> rsp_valid_o);

  a_r9_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active) |=> !rsp_valid_o);

  a_r8_dbg_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_dbg_o |-> mgmt_wr_o);
endmodule

bind cfg_access_req cfgreq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
  .cmd_byte_addr_i(cmd_byte_addr_i), .rsp_valid_o(rsp_valid_o), .mgmt_addr_o(mgmt_addr_o),
  .mgmt_func_o(mgmt_func_o), .mgmt_wdata_o(mgmt_wdata_o), .mgmt_be_o(mgmt_be_o),
  .mgmt_wr_o(mgmt_wr_o), .mgmt_rd_o(mgmt_rd_o), .mgmt_dbg_o(mgmt_dbg_o),
  .mgmt_done_i(mgmt_done_i)
);

// File: tb/tb_cfg_access_req.sv
`timescale 1ns/1ps
module tb_cfg_access_req;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        cmd_valid = 0, cmd_write = 0, cmd_dbg = 0;
  logic [11:0] cmd_baddr = 0;
  logic [7:0]  cmd_func = 0;
  logic [31:0] cmd_wdata = 0;
  logic [3:0]  cmd_be = 0;
  logic        cmd_ready, rsp_valid, rsp_write;
  logic [31:0] rsp_rdata, m_wdata;
  logic [9:0]  m_addr;
  logic [7:0]  m_func;
  logic [3:0]  m_be;
  logic        m_wr, m_rd, m_dbg;
  logic [31:0] m_rdata = 0;
  logic        m_done = 0;

  cfg_access_req dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_write_i(cmd_write), .cmd_byte_addr_i(cmd_baddr), .cmd_func_i(cmd_func),
    .cmd_wdata_i(cmd_wdata), .cmd_be_i(cmd_be), .cmd_dbg_i(cmd_dbg),
    .rsp_valid_o(rsp_valid), .rsp_write_o(rsp_write), .rsp_rdata_o(rsp_rdata),
    .mgmt_addr_o(m_addr), .mgmt_func_o(m_func), .mgmt_wdata_o(m_wdata), .mgmt_be_o(m_be),
    .mgmt_wr_o(m_wr), .mgmt_rd_o(m_rd), .mgmt_dbg_o(m_dbg),
    .mgmt_rdata_i(m_rdata), .mgmt_done_i(m_done)
  );

  typedef struct packed {
    logic wr; logic dbg; logic [9:0] addr; logic [7:0] func; logic [31:0] wdata; logic [3:0] be;
  } exp_req_t;
  typedef struct packed { logic wr; logic [31:0] rdata; } exp_rsp_t;

  exp_req_t req_q[$];
  exp_rsp_t rsp_q[$];
  int checks = 0, fails = 0, lat = 0, issued = 0, got = 0;
  bit inject_spur = 0;

  function automatic logic [31:0] mk_rdata(logic [9:0] a, logic [7:0] f);
    return {f, 12'h0, 2'b0, a} ^ 32'h5A3C_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: waits for ready, presents command for one accepting edge
  task automatic issue(input bit wr, input logic [11:0] ba, input logic [7:0] f,
                       input logic [31:0] wd, input logic [3:0] be, input bit dbg);
    exp_req_t r;
    exp_rsp_t s;
    while (!cmd_ready) @(negedge clk);
    r.wr = wr; r.dbg = wr && dbg; r.addr = ba[11:2]; r.func = f; r.wdata = wd; r.be = be;
    s.wr = wr; s.rdata = mk_rdata(ba[11:2], f);
    req_q.push_back(r); rsp_q.push_back(s); issued++;
    cmd_valid = 1; cmd_write = wr; cmd_baddr = ba; cmd_func = f;
    cmd_wdata = wd; cmd_be = be; cmd_dbg = dbg;
    @(negedge clk);
    cmd_valid = 0; cmd_dbg = 0;
    chk(!cmd_ready, "R6 ready low after accept", cmd_ready, 0);
  endtask

  // management-port responder with programmable latency
  initial begin
    forever begin
      @(negedge clk);
      if (inject_spur) begin
        m_done = 1;
        @(negedge clk);
        m_done = 0;
        chk(!rsp_valid && !m_wr && !m_rd, "R9 idle done ignored", {rsp_valid, m_wr, m_rd}, 0);
        inject_spur = 0;
      end else if (m_wr || m_rd) begin
        exp_req_t e;
        bit ok;
        int n;
        logic [9:0] a0; logic [7:0] f0; logic [31:0] w0; logic [3:0] b0; logic wr0;
        if (req_q.size() == 0) begin
          chk(0, "R5 unexpected request", 1, 0);
          e = '0;
        end else e = req_q.pop_front();
        chk(m_addr == e.addr, "R2 dword address", m_addr, e.addr);
        chk(m_func == e.func, "R2 function", m_func, e.func);
        chk(m_wr == e.wr && m_rd == !e.wr, "R5 strobe kind", {m_wr, m_rd}, {e.wr, !e.wr});
        if (e.wr) begin
          chk(m_wdata == e.wdata && m_be == e.be, "R5 write payload", {m_wdata, m_be}, {e.wdata, e.be});
        end
        chk(m_dbg == e.dbg, "R8 debug qualifier", m_dbg, e.dbg);
        a0 = m_addr; f0 = m_func; w0 = m_wdata; b0 = m_be; wr0 = m_wr;
        ok = 1; n = 0;
        while (n < lat) begin
          @(negedge clk); n++;
          ok &= (m_addr == a0) && (m_func == f0) && (m_wdata == w0) && (m_be == b0)
                && (m_wr == wr0) && (m_rd == !wr0) && !cmd_ready && (m_dbg == e.dbg);
        end
        chk(ok, "R3 hold until done", ok, 1);
        m_done = 1; m_rdata = mk_rdata(e.addr, e.func);
        @(negedge clk);
        m_done = 0; m_rdata = 32'hDEAD_BEEF;
        chk(!m_wr && !m_rd, "R4 strobe drops after done", {m_wr, m_rd}, 0);
        chk(cmd_ready, "R6 ready back after done", cmd_ready, 1);
        chk(!m_dbg, "R8 dbg low when idle", m_dbg, 0);
      end
    end
  end

  // monitor: pops expected responses
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        exp_rsp_t s;
        got++;
        if (rsp_q.size() == 0) chk(0, "R7 unexpected response", 1, 0);
        else begin
          s = rsp_q.pop_front();
          chk(rsp_write == s.wr, "R7 response kind", rsp_write, s.wr);
          if (!s.wr) chk(rsp_rdata == s.rdata, "R7 read data", rsp_rdata, s.rdata);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    chk(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready && !m_wr && !m_rd && !m_dbg && !rsp_valid, "R1 reset state",
        {cmd_ready, m_wr, m_rd, m_dbg, rsp_valid}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !m_wr && !m_rd && !rsp_valid, "R1 idle after reset release",
        {cmd_ready, m_wr, m_rd, rsp_valid}, 4'b1000);

    lat = 3; issue(0, 12'h004, 8'h00, '0, '0, 0);          // R2 byte 04 -> dword 01
    lat = 0; issue(0, 12'h010, 8'h03, '0, '0, 1);          // R8 dbg ignored on read
    lat = 1; issue(1, 12'h013, 8'h7F, 32'hCAFE_F00D, 4'b1010, 1); // unaligned, dbg write
    lat = 5; issue(1, 12'hFFC, 8'hFF, 32'h1234_5678, 4'b0000, 0); // R5 empty mask
    lat = 0; issue(1, 12'h008, 8'h01, 32'hA5A5_A5A5, 4'b1111, 0);
    lat = 0; issue(0, 12'h3FF, 8'h80, '0, '0, 0);
    lat = 2; issue(0, 12'hABE, 8'h11, '0, '0, 0);

    while (req_q.size() != 0 || rsp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    inject_spur = 1;                                        // R9
    while (inject_spur) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(got == issued, "R7 one response per command", got, issued);
    chk(cmd_ready && !m_wr && !m_rd, "R9 still idle", {cmd_ready, m_wr, m_rd}, 3'b100);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule